// File: doc/BRIEF.md
# Grouped Interrupt Expander with Per-Group Acknowledge

This block gathers many single-cycle peripheral interrupt requests and presents them to a CPU on a small number of interrupt lines. The sources are split into groups of eight, and each group drives one CPU line. Each source has a pending flag and an enable bit. Each group has a one-bit acknowledge latch that closes after the group forwards one request, so the CPU sees at most one outstanding request per group.

When the CPU starts servicing a line, it strobes a service-entry input with the group number. In that same cycle the block returns a vector that names the group and the highest-priority pending, enabled source. On the next clock edge it clears that source's pending flag and the group's CPU-level flag. Software re-arms a group by writing a 1 to its acknowledge bit. If another enabled source in the group is still pending at that point, it is forwarded straight away.

Register writes load a group's enables and clear pending flags by hand. There are no other software-visible controls.

Top module: `grp_irq_expander`

## Requirements
- R1: After reset, every pending flag and enable bit is 0, every group's acknowledge latch is open, `cpuFlag` and `cpuFlagSet` are all 0, and a service entry returns `svcVecValid` = 0.
- R2: A one-cycle pulse on `reqPulse[g*8+s]` sets the pending flag of source s in group g on the next edge. The flag stays set until it is serviced or cleared by software. A pulse that arrives while the flag is already set is absorbed, so one service clears it completely.
- R3: A write with `clrWrEn` = 1 clears the pending flags of group `clrWrGroup` wherever `clrWrData` has a 1 (bit s is source s). A flag cleared this way is never forwarded, even if it is enabled later.
- R4: Each group forwards a request when its latch is open and it has at least one source that is both pending and enabled. Forwarding raises `cpuFlagSet[g]` for one cycle and sets `cpuFlag[g]` on the second clock edge after the request pulse or the enable write. A pending source whose enable bit is 0 is not forwarded. A `enWrEn` write replaces group `enWrGroup`'s enables with `enWrData`.
- R5: Forwarding closes the group's acknowledge latch. While the latch is closed, no further `cpuFlagSet[g]` is raised, whatever becomes pending.
- R6: `ackWrData` is write-1-to-clear: with `ackWrEn` = 1, a 1 in bit g opens group g's latch and a 0 bit has no effect. If the group still has a pending, enabled source, `cpuFlagSet[g]` is raised on the second edge after the acknowledge write.
- R7: Within a group, the lowest source index has the highest priority. During a `svcEntry` cycle, `svcVector` = `svcGroup`*8 + s, where s is the lowest-index source that is both pending and enabled. `svcVecValid` is 1 only if such a source exists.
- R8: On the edge that ends a `svcEntry` cycle, the block clears the pending flag of the reported source and `cpuFlag[svcGroup]`. Other flags are left unchanged.
- R9: If a request pulse and the service-entry clear of the same flag fall in the same cycle, the flag remains set.
- R10: Groups are independent. Requests, services and acknowledges in one group do not change another group's flags or latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqPulse | input | 32 | Peripheral request pulses, line g*8+s is source s of group g |
| enWrEn | input | 1 | Enable register write strobe |
| enWrGroup | input | 2 | Group whose enables are written |
| enWrData | input | 8 | New enable bits, bit s for source s |
| clrWrEn | input | 1 | Pending-clear write strobe |
| clrWrGroup | input | 2 | Group whose pending flags are cleared |
| clrWrData | input | 8 | 1 bits clear the matching pending flags |
| ackWrEn | input | 1 | Acknowledge write strobe |
| ackWrData | input | 4 | Write-1-to-clear acknowledge, bit g opens group g |
| svcEntry | input | 1 | CPU service-entry strobe |
| svcGroup | input | 2 | Group (CPU line) being serviced |
| svcVecValid | output | 1 | A pending, enabled source exists for the serviced group |
| svcVector | output | 5 | Serviced group times 8 plus source index |
| cpuFlagSet | output | 4 | One-cycle pulse per group when a request is forwarded |
| cpuFlag | output | 4 | CPU-level flag per group, cleared on service entry |

## Verification
A pending flag that is lost or stuck shows up at the next service entry of its group as a wrong `svcVector` or `svcVecValid`. It also shows up as a forward that is missing or extra two edges after the acknowledge write. A latch held in the wrong state appears within two edges of the stimulus, as a `cpuFlagSet` pulse during a blocked window or no pulse after a re-arm. The directed scenarios put every flag into a state where the next service entry or acknowledge makes it visible, so each fault is observed within a few cycles of its cause.

// File: rtl/irqx_pkg.sv
package irqx_pkg;
  localparam int GROUPS = 4;
  localparam int SRCS   = 8;
  localparam int GRP_W  = $clog2(GROUPS);
  localparam int SRC_W  = $clog2(SRCS);
  localparam int LINES  = GROUPS * SRCS;
  localparam int VEC_W  = GRP_W + SRC_W;

  // strobes from control to datapath
  typedef struct packed {
    logic [GROUPS-1:0] svcSel;   // one-hot: group entering service this cycle
  } ctrl_strobe_t;
endpackage

// File: rtl/irqx_prio_enc.sv
module irqx_prio_enc #(
  parameter int W  = 8,
  localparam int IW = $clog2(W)
) (
  input  logic [W-1:0]  reqVec,
  output logic          hit,
  output logic [IW-1:0] idx
);
  // lowest index wins
  always_comb begin
    idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (reqVec[i]) idx = IW'(i);
    end
  end

  assign hit = |reqVec;
endmodule

// File: rtl/irqx_datapath.sv
module irqx_datapath
  import irqx_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [LINES-1:0]   reqPulse,
  input  logic               enWrEn,
  input  logic [GRP_W-1:0]   enWrGroup,
  input  logic [SRCS-1:0]    enWrData,
  input  logic               clrWrEn,
  input  logic [GRP_W-1:0]   clrWrGroup,
  input  logic [SRCS-1:0]    clrWrData,
  input  ctrl_strobe_t       strobe,
  output logic [GROUPS-1:0]  anyReq,
  output logic               svcVecValid,
  output logic [VEC_W-1:0]   svcVector
);
  logic [LINES-1:0] pendQ;
  logic [LINES-1:0] enQ;
  logic [LINES-1:0] liveReq;
  logic [LINES-1:0] svcClrMask;
  logic [LINES-1:0] swClrMask;
  logic [GROUPS-1:0][SRC_W-1:0] topIdx;

  for (genvar g = 0; g < GROUPS; g++) begin : gen_grp
    localparam int Lo = g * SRCS;
    logic [SRCS-1:0] grpLive;

    assign grpLive = pendQ[Lo +: SRCS] & enQ[Lo +: SRCS];
    assign liveReq[Lo +: SRCS] = grpLive;

    irqx_prio_enc #(.W(SRCS)) u_enc (
      .reqVec (grpLive),
      .hit    (anyReq[g]),
      .idx    (topIdx[g])
    );

    always_comb begin
      svcClrMask[Lo +: SRCS] = (strobe.svcSel[g] && anyReq[g])
                             ? (SRCS'(1) << topIdx[g]) : '0;
      swClrMask[Lo +: SRCS]  = (clrWrEn && clrWrGroup == GRP_W'(g))
                             ? clrWrData : '0;
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        enQ[Lo +: SRCS] <= '0;
      end else if (enWrEn && enWrGroup == GRP_W'(g)) begin
        enQ[Lo +: SRCS] <= enWrData;
      end
    end

    // R7
    prio_low_chk: assert property (@(posedge clk) disable iff (!rstN)
      anyReq[g] |-> (grpLive[topIdx[g]] &&
        ((grpLive & ((SRCS'(1) << topIdx[g]) - SRCS'(1))) == '0)));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendQ <= '0;
    end else begin
      pendQ <= (pendQ & ~svcClrMask & ~swClrMask) | reqPulse;
    end
  end

  // vector for the group entering service
  always_comb begin
    svcVecValid = 1'b0;
    svcVector   = '0;
    for (int i = 0; i < GROUPS; i++) begin
      if (strobe.svcSel[i]) begin
        svcVecValid = anyReq[i];
        svcVector   = {GRP_W'(i), topIdx[i]};
      end
    end
  end

  // R2
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (($past(pendQ & ~svcClrMask & ~swClrMask) & ~pendQ) == '0));

  // R9
  pulse_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (($past(reqPulse) & ~pendQ) == '0));

  // R8
  svc_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (svcVecValid && $countones(reqPulse & svcClrMask) == 0)
      |=> (($past(svcClrMask) & pendQ) == '0));
endmodule

// File: rtl/irqx_ctrl.sv
module irqx_ctrl
  import irqx_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               svcEntry,
  input  logic [GRP_W-1:0]   svcGroup,
  input  logic               ackWrEn,
  input  logic [GROUPS-1:0]  ackWrData,
  input  logic [GROUPS-1:0]  anyReq,
  output ctrl_strobe_t       strobe,
  output logic [GROUPS-1:0]  cpuFlagSet,
  output logic [GROUPS-1:0]  cpuFlag
);
  logic [GROUPS-1:0] blockedQ;
  logic [GROUPS-1:0] ackHit;
  logic [GROUPS-1:0] fwd;

  assign ackHit = ackWrEn ? ackWrData : '0;
  assign fwd    = ~blockedQ & anyReq;

  always_comb begin
    strobe.svcSel = '0;
    for (int i = 0; i < GROUPS; i++) begin
      if (svcEntry && svcGroup == GRP_W'(i)) strobe.svcSel[i] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      blockedQ   <= '0;
      cpuFlag    <= '0;
      cpuFlagSet <= '0;
    end else begin
      blockedQ   <= (blockedQ & ~ackHit) | fwd;
      cpuFlag    <= (cpuFlag & ~strobe.svcSel) | fwd;
      cpuFlagSet <= fwd;
    end
  end

  // R5
  blocked_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((cpuFlagSet & $past(blockedQ & ~ackHit)) == '0));

  // R4
  flag_follows_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cpuFlagSet & ~cpuFlag) == '0);

  // R8
  svc_flag_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    svcEntry |=> (!cpuFlag[$past(svcGroup)] || cpuFlagSet[$past(svcGroup)]));

  // R6
  ack_open_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (($past(ackHit & ~fwd) & blockedQ) == '0));
endmodule

// File: rtl/grp_irq_expander.sv
module grp_irq_expander
  import irqx_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [LINES-1:0]   reqPulse,
  input  logic               enWrEn,
  input  logic [GRP_W-1:0]   enWrGroup,
  input  logic [SRCS-1:0]    enWrData,
  input  logic               clrWrEn,
  input  logic [GRP_W-1:0]   clrWrGroup,
  input  logic [SRCS-1:0]    clrWrData,
  input  logic               ackWrEn,
  input  logic [GROUPS-1:0]  ackWrData,
  input  logic               svcEntry,
  input  logic [GRP_W-1:0]   svcGroup,
  output logic               svcVecValid,
  output logic [VEC_W-1:0]   svcVector,
  output logic [GROUPS-1:0]  cpuFlagSet,
  output logic [GROUPS-1:0]  cpuFlag
);
  ctrl_strobe_t      strobe;
  logic [GROUPS-1:0] anyReq;

  irqx_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .svcEntry   (svcEntry),
    .svcGroup   (svcGroup),
    .ackWrEn    (ackWrEn),
    .ackWrData  (ackWrData),
    .anyReq     (anyReq),
    .strobe     (strobe),
    .cpuFlagSet (cpuFlagSet),
    .cpuFlag    (cpuFlag)
  );

  irqx_datapath u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .reqPulse    (reqPulse),
    .enWrEn      (enWrEn),
    .enWrGroup   (enWrGroup),
    .enWrData    (enWrData),
    .clrWrEn     (clrWrEn),
    .clrWrGroup  (clrWrGroup),
    .clrWrData   (clrWrData),
    .strobe      (strobe),
    .anyReq      (anyReq),
    .svcVecValid (svcVecValid),
    .svcVector   (svcVector)
  );
endmodule

// File: tb/grp_irq_expander_bench.sv
module grp_irq_expander_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] reqPulse = '0;
  logic        enWrEn = 1'b0;
  logic [1:0]  enWrGroup = '0;
  logic [7:0]  enWrData = '0;
  logic        clrWrEn = 1'b0;
  logic [1:0]  clrWrGroup = '0;
  logic [7:0]  clrWrData = '0;
  logic        ackWrEn = 1'b0;
  logic [3:0]  ackWrData = '0;
  logic        svcEntry = 1'b0;
  logic [1:0]  svcGroup = '0;
  logic        svcVecValid;
  logic [4:0]  svcVector;
  logic [3:0]  cpuFlagSet;
  logic [3:0]  cpuFlag;

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  grp_irq_expander u_grp_irq_expander (
    .clk(clk), .rstN(rstN), .reqPulse(reqPulse),
    .enWrEn(enWrEn), .enWrGroup(enWrGroup), .enWrData(enWrData),
    .clrWrEn(clrWrEn), .clrWrGroup(clrWrGroup), .clrWrData(clrWrData),
    .ackWrEn(ackWrEn), .ackWrData(ackWrData),
    .svcEntry(svcEntry), .svcGroup(svcGroup),
    .svcVecValid(svcVecValid), .svcVector(svcVector),
    .cpuFlagSet(cpuFlagSet), .cpuFlag(cpuFlag)
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic checkEq(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pulse(input int line);
    reqPulse[line] = 1'b1; tick(); reqPulse = '0;
  endtask

  task automatic setEn(input int g, input logic [7:0] d);
    enWrEn = 1'b1; enWrGroup = 2'(g); enWrData = d; tick(); enWrEn = 1'b0;
  endtask

  task automatic swClr(input int g, input logic [7:0] d);
    clrWrEn = 1'b1; clrWrGroup = 2'(g); clrWrData = d; tick(); clrWrEn = 1'b0;
  endtask

  task automatic ack(input logic [3:0] m);
    ackWrEn = 1'b1; ackWrData = m; tick(); ackWrEn = 1'b0;
  endtask

  task automatic service(input int g, input bit expValid, input int expVec, input string tag);
    svcEntry = 1'b1; svcGroup = 2'(g); #1;
    checkEq({tag, " vector valid"}, int'(svcVecValid), int'(expValid));
    if (expValid) checkEq({tag, " vector"}, int'(svcVector), expVec);
    tick(); svcEntry = 1'b0;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  endtask

  task automatic testReset();
    checkEq("R1 cpuFlag", int'(cpuFlag), 0);
    checkEq("R1 cpuFlagSet", int'(cpuFlagSet), 0);
    service(0, 1'b0, 0, "R1 group0");
    service(3, 1'b0, 0, "R1 group3");
  endtask

  task automatic testBasic();
    setEn(0, 8'hFF);
    pulse(3); tick();
    checkEq("R4 forward pulse", int'(cpuFlagSet), 1);
    checkEq("R4 cpu flag set", int'(cpuFlag), 1);
    tick();
    checkEq("R4 pulse one cycle", int'(cpuFlagSet), 0);
    checkEq("R2 flag held", int'(cpuFlag), 1);
    service(0, 1'b1, 3, "R7 basic");
    checkEq("R8 cpu flag cleared", int'(cpuFlag), 0);
    ack(4'b0001); tick(); tick();
    checkEq("R8 pending cleared no reforward", int'(cpuFlagSet), 0);
    service(0, 1'b0, 0, "R8 empty after service");
  endtask

  task automatic testPriorityAck();
    setEn(1, 8'hFF);
    pulse(13); tick();
    checkEq("R4 group1 forward", int'(cpuFlagSet), 4'b0010);
    pulse(10); tick(); tick();
    checkEq("R5 blocked no pulse", int'(cpuFlagSet), 0);
    checkEq("R5 cpu flag still", int'(cpuFlag), 4'b0010);
    ack(4'b1101); tick(); tick();
    checkEq("R6 zero bit no effect", int'(cpuFlagSet), 0);
    service(1, 1'b1, 10, "R7 lowest index wins");
    ack(4'b0010); tick();
    checkEq("R6 reforward after ack", int'(cpuFlagSet), 4'b0010);
    service(1, 1'b1, 13, "R7 next source");
    ack(4'b0010); tick(); tick();
    checkEq("R6 nothing left", int'(cpuFlagSet), 0);
  endtask

  task automatic testDisabled();
    setEn(2, 8'h0F);
    pulse(22); tick(); tick();
    checkEq("R4 disabled not forwarded", int'(cpuFlagSet), 0);
    setEn(2, 8'hFF); tick();
    checkEq("R4 forward after enable", int'(cpuFlagSet), 4'b0100);
    service(2, 1'b1, 22, "R7 group2");
    ack(4'b0100);
  endtask

  task automatic testSwClear();
    setEn(3, 8'h00);
    pulse(25); pulse(26);
    swClr(3, 8'h02);
    setEn(3, 8'h02); tick(); tick();
    checkEq("R3 cleared not forwarded", int'(cpuFlagSet), 0);
    service(3, 1'b0, 0, "R3 cleared flag gone");
    setEn(3, 8'hFF); tick();
    checkEq("R3 other flag kept", int'(cpuFlagSet), 4'b1000);
    service(3, 1'b1, 26, "R3 remaining source");
    ack(4'b1000);
  endtask

  task automatic testAbsorb();
    pulse(4); pulse(4);
    checkEq("R2 forward once", int'(cpuFlagSet), 1);
    service(0, 1'b1, 4, "R2 absorbed service");
    ack(4'b0001); tick(); tick();
    checkEq("R2 no second request", int'(cpuFlagSet), 0);
    service(0, 1'b0, 0, "R2 absorbed cleared");
  endtask

  task automatic testCollision();
    pulse(0); tick();
    checkEq("R9 first forward", int'(cpuFlagSet), 1);
    reqPulse[0] = 1'b1;
    service(0, 1'b1, 0, "R9 service");
    reqPulse = '0;
    ack(4'b0001); tick();
    checkEq("R9 flag survived", int'(cpuFlagSet), 1);
    service(0, 1'b1, 0, "R9 second service");
    ack(4'b0001); tick(); tick();
    checkEq("R9 finally clear", int'(cpuFlagSet), 0);
  endtask

  task automatic testIndependent();
    reqPulse[8] = 1'b1; reqPulse[23] = 1'b1; tick(); reqPulse = '0; tick();
    checkEq("R10 both groups forward", int'(cpuFlagSet), 4'b0110);
    service(1, 1'b1, 8, "R10 group1");
    checkEq("R10 group2 flag untouched", int'(cpuFlag), 4'b0100);
    service(2, 1'b1, 23, "R10 group2");
    checkEq("R10 all flags clear", int'(cpuFlag), 0);
    ack(4'b0110); tick(); tick();
    checkEq("R10 quiet after ack", int'(cpuFlagSet), 0);
  endtask

  initial begin
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    testReset();
    testBasic();
    testPriorityAck();
    testDisabled();
    testSwClear();
    testAbsorb();
    testCollision();
    testIndependent();
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog actual=0 expected=1");
    summary();
  end
endmodule